// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a user-mode virtual address into a physical address by reading two levels of page table from memory. A requester presents an address and a read/write flag with a valid/ready handshake. The walker fetches a first-level entry, then a second-level (leaf) entry, and builds the physical address from the leaf. If the access is a write and the leaf's dirty flag is clear, it writes the entry back with the dirty flag set. It answers with a one-cycle response that carries either the physical address or a page-fault flag. On a fault it keeps the faulting virtual address for the trap logic.

The page sizes at both levels come from a runtime size register. Its upper half holds log2 of the leaf page size (L2) and its lower half holds log2 of the region one first-level entry covers (L1). Second-level tables need only word alignment. Translation is skipped entirely in system mode, or when the translate-enable bit is clear. In that case the virtual address comes back unchanged and memory is never touched.

Top module: `pgwalk_top`

## Requirements
- R1: When `cfg_sys_mode` is 1 or `cfg_xlate_en` is 0, an accepted request is answered on the next cycle with `rsp_fault`=0 and `rsp_paddr` equal to the request address, with no memory access.
- R2: In user mode with translation enabled, a request whose address bit 31 is set is answered with `rsp_fault`=1 and no memory access.
- R3: The first-level entry is read from `ptbase + 4*(va >> L1)`, where L1 is taken from `cfg_ptsize[15:0]` and L2 from `cfg_ptsize[31:16]` (assumed L2 < L1 < 31). The config is sampled when the request is accepted.
- R4: The leaf entry is read from `(pte1 & ~3) + 4*((va >> L2) mod 2^(L1-L2))`. The table pointer needs no page alignment.
- R5: On success, `rsp_paddr = (leaf & ~(2^L2-1)) + (va mod 2^L2)`.
- R6: An entry at either level with bit 0 (valid) clear gives `rsp_fault`=1. `fault_vaddr` then holds that request's address and changes only when a fault is reported.
- R7: A write whose leaf has bit 1 (dirty) clear writes `leaf | 2` back to the leaf's address. A read, or a write to an already-dirty leaf, performs no memory write. Bit 1 is never cleared by the block.
- R8: `req_ready` is high only while idle. `rsp_valid` is a single-cycle pulse.
- R9: A memory request (`mem_valid`, `mem_we`, `mem_addr`, `mem_wdata`) stays stable until `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle, request accepted this cycle |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | Access is a write |
| cfg_ptbase | input | 32 | First-level table base address |
| cfg_ptsize | input | 32 | log2 page size [31:16], log2 region size [15:0] |
| cfg_xlate_en | input | 1 | Page-table translation enabled |
| cfg_sys_mode | input | 1 | CPU in system mode |
| mem_valid | output | 1 | Memory access request |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | 32 | Memory word address (byte addressed) |
| mem_wdata | output | 32 | Write data (leaf entry with dirty set) |
| mem_ack | input | 1 | Memory completes the access this cycle |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| rsp_valid | output | 1 | Response pulse |
| rsp_fault | output | 1 | Response is a page fault |
| rsp_paddr | output | 32 | Translated physical address |
| fault_vaddr | output | 32 | Address of the most recent fault |

## Verification
The hardest case to reach is a dirty-bit writeback that happens while memory stalls. The leaf must be valid and clean, the access must be a write, and the memory must hold off its acknowledge while the write is pending. The bench builds its tables lazily, with random validity and dirty flags, and it re-uses a few regions so that later writes find entries that are already dirty. The memory model acknowledges at random, so every memory phase sees stalls. Random size configurations exercise the variable index split. Directed cases cover the region above the translated range and both bypass conditions.

// File: rtl/pgwalk_pkg.sv
`timescale 1ns/1ps
// Shared types for the page table walker.
package pgwalk_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD1,
        ST_RD2,
        ST_WB,
        ST_DONE,
        ST_FAULT
    } walk_st_e;

    localparam int PTE_VALID_BIT = 0;
    localparam int PTE_DIRTY_BIT = 1;
    localparam int PTE_LOG_BYTES = 2;
endpackage

// File: rtl/pgwalk_gate.sv
`timescale 1ns/1ps
// pgwalk_gate: decides whether a request bypasses translation, or is
// rejected because its address lies above the translated range.
// Assumes the top address bit marks the untranslated upper half.
module pgwalk_gate #(
    parameter int AW = 32
) (
    input  logic [AW-1:0] vaddr,
    input  logic          xlate_en,
    input  logic          sys_mode,
    output logic          bypass,
    output logic          range_fault
);
    // Classify the request from mode, enable and the address top bit.
    always_comb begin
        bypass      = sys_mode || !xlate_en;
        range_fault = !bypass && vaddr[AW-1];
    end
endmodule

// File: rtl/pgwalk_addr.sv
`timescale 1ns/1ps
// pgwalk_addr: address arithmetic for both table levels and the final
// physical address. Assumes l2_log < l1_log < AW-1; the shift amounts are
// runtime values.
module pgwalk_addr
    import pgwalk_pkg::*;
#(
    parameter int AW = 32,
    parameter int SW = 5
) (
    input  logic [AW-1:0] vaddr,
    input  logic [AW-1:0] ptbase,
    input  logic [SW-1:0] l1_log,
    input  logic [SW-1:0] l2_log,
    input  logic [AW-1:0] l1_pte,
    input  logic [AW-1:0] leaf_pte,
    output logic [AW-1:0] l1_pte_addr,
    output logic [AW-1:0] l2_pte_addr,
    output logic [AW-1:0] phys_addr
);
    localparam logic [AW-1:0] ONE       = {{(AW-1){1'b0}}, 1'b1};
    localparam logic [AW-1:0] WORD_MASK = ~((ONE << PTE_LOG_BYTES) - ONE);

    logic [AW-1:0] va_lo;
    logic [AW-1:0] idx2_mask;
    logic [AW-1:0] off_mask;

    // Build the index masks from the runtime size fields.
    always_comb begin
        va_lo     = {1'b0, vaddr[AW-2:0]};
        idx2_mask = (ONE << (l1_log - l2_log)) - ONE;
        off_mask  = (ONE << l2_log) - ONE;
    end

    // Form the two entry addresses and the translated address.
    always_comb begin
        l1_pte_addr = ptbase + ((va_lo >> l1_log) << PTE_LOG_BYTES);
        l2_pte_addr = (l1_pte & WORD_MASK)
                    + (((va_lo >> l2_log) & idx2_mask) << PTE_LOG_BYTES);
        phys_addr   = (leaf_pte & ~off_mask) + (vaddr & off_mask);
    end
endmodule

// File: rtl/pgwalk_top.sv
`timescale 1ns/1ps
// pgwalk_top: two-level page table walker. Takes one request at a time,
// reads the first-level and leaf entries, optionally writes the leaf back
// with its dirty bit set, then gives a one-cycle response. The config is
// sampled at acceptance. Memory holds a request until mem_ack, and read
// data is valid with the ack.
module pgwalk_top
    import pgwalk_pkg::*;
#(
    parameter int AW = 32,
    parameter int SW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [AW-1:0] req_vaddr,
    input  logic          req_write,
    input  logic [AW-1:0] cfg_ptbase,
    input  logic [AW-1:0] cfg_ptsize,
    input  logic          cfg_xlate_en,
    input  logic          cfg_sys_mode,
    output logic          mem_valid,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [AW-1:0] mem_wdata,
    input  logic          mem_ack,
    input  logic [AW-1:0] mem_rdata,
    output logic          rsp_valid,
    output logic          rsp_fault,
    output logic [AW-1:0] rsp_paddr,
    output logic [AW-1:0] fault_vaddr
);
    localparam int HALF = AW / 2;

    walk_st_e      st_q;
    logic [AW-1:0] va_q, base_q, pte1_q, leaf_q, paddr_q, fva_q;
    logic          wr_q;
    logic [SW-1:0] l1_q, l2_q;
    logic          bypass, range_fault;
    logic [AW-1:0] a1, a2, pa;
    logic          cfg_unused;

    // Mark the size-field bits above the shift width as deliberately unused.
    assign cfg_unused = ^{cfg_ptsize[AW-1:HALF+SW], cfg_ptsize[HALF-1:SW]};

    pgwalk_gate #(.AW(AW)) gate_i (
        .vaddr       (req_vaddr),
        .xlate_en    (cfg_xlate_en),
        .sys_mode    (cfg_sys_mode),
        .bypass      (bypass),
        .range_fault (range_fault)
    );

    pgwalk_addr #(.AW(AW), .SW(SW)) addr_i (
        .vaddr       (va_q),
        .ptbase      (base_q),
        .l1_log      (l1_q),
        .l2_log      (l2_q),
        .l1_pte      (pte1_q),
        .leaf_pte    (mem_rdata),
        .l1_pte_addr (a1),
        .l2_pte_addr (a2),
        .phys_addr   (pa)
    );

    // Walk state machine plus the captured request and config.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= ST_IDLE;
            va_q    <= '0;
            base_q  <= '0;
            pte1_q  <= '0;
            leaf_q  <= '0;
            paddr_q <= '0;
            fva_q   <= '0;
            wr_q    <= 1'b0;
            l1_q    <= '0;
            l2_q    <= '0;
        end else begin
            case (st_q)
                ST_IDLE: if (req_valid) begin
                    va_q   <= req_vaddr;
                    wr_q   <= req_write;
                    base_q <= cfg_ptbase;
                    l1_q   <= cfg_ptsize[SW-1:0];
                    l2_q   <= cfg_ptsize[HALF+SW-1:HALF];
                    if (bypass) begin
                        paddr_q <= req_vaddr;
                        st_q    <= ST_DONE;
                    end else if (range_fault) begin
                        fva_q <= req_vaddr;
                        st_q  <= ST_FAULT;
                    end else begin
                        st_q <= ST_RD1;
                    end
                end
                ST_RD1: if (mem_ack) begin
                    pte1_q <= mem_rdata;
                    if (mem_rdata[PTE_VALID_BIT]) begin
                        st_q <= ST_RD2;
                    end else begin
                        fva_q <= va_q;
                        st_q  <= ST_FAULT;
                    end
                end
                ST_RD2: if (mem_ack) begin
                    leaf_q  <= mem_rdata;
                    paddr_q <= pa;
                    if (!mem_rdata[PTE_VALID_BIT]) begin
                        fva_q <= va_q;
                        st_q  <= ST_FAULT;
                    end else if (wr_q && !mem_rdata[PTE_DIRTY_BIT]) begin
                        st_q <= ST_WB;
                    end else begin
                        st_q <= ST_DONE;
                    end
                end
                ST_WB: if (mem_ack) st_q <= ST_DONE;
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    // Drive memory and response ports from the current state.
    always_comb begin
        req_ready   = (st_q == ST_IDLE);
        mem_valid   = (st_q == ST_RD1) || (st_q == ST_RD2) || (st_q == ST_WB);
        mem_we      = (st_q == ST_WB);
        mem_addr    = (st_q == ST_RD1) ? a1 : a2;
        mem_wdata   = leaf_q;
        mem_wdata[PTE_DIRTY_BIT] = 1'b1;
        rsp_valid   = (st_q == ST_DONE) || (st_q == ST_FAULT);
        rsp_fault   = (st_q == ST_FAULT);
        rsp_paddr   = paddr_q;
        fault_vaddr = fva_q;
    end
endmodule

// File: rtl/pgwalk_chk.sv
`timescale 1ns/1ps
// pgwalk_chk: protocol and response properties of the walker, bound to
// every instance of pgwalk_top.
module pgwalk_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic          req_ready,
    input logic [AW-1:0] req_vaddr,
    input logic          cfg_xlate_en,
    input logic          cfg_sys_mode,
    input logic          mem_valid,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input logic [AW-1:0] mem_wdata,
    input logic          mem_ack,
    input logic          rsp_valid,
    input logic          rsp_fault,
    input logic [AW-1:0] rsp_paddr,
    input logic [AW-1:0] fault_vaddr
);
    a_r1_bypass_next: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && (cfg_sys_mode || !cfg_xlate_en))
        |=> (rsp_valid && !rsp_fault && !mem_valid && rsp_paddr == $past(req_vaddr)));

    a_r2_high_fault: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !cfg_sys_mode && cfg_xlate_en && req_vaddr[AW-1])
        |=> (rsp_valid && rsp_fault && !mem_valid));

    a_r6_fva_only_on_fault: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(fault_vaddr) |-> (rsp_valid && rsp_fault));

    a_r7_wb_sets_dirty: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && mem_we) |-> mem_wdata[1]);

    a_r8_not_ready_in_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready);

    a_r8_rsp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    a_r9_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ack) |=> (mem_valid && $stable(mem_we)
                                     && $stable(mem_addr) && $stable(mem_wdata)));
endmodule

bind pgwalk_top pgwalk_chk #(.AW(AW)) chk_i (.*);

// File: tb/pgwalk_top_tb_top.sv
`timescale 1ns/1ps
module pgwalk_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0, cfg_ptbase = '0, cfg_ptsize = '0;
    logic        cfg_xlate_en = 1'b0, cfg_sys_mode = 1'b0;
    logic        mem_valid, mem_we, mem_ack = 1'b0;
    logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;
    logic        rsp_valid, rsp_fault;
    logic [31:0] rsp_paddr, fault_vaddr;

    int total = 0, bad = 0, nreads = 0, nwrites = 0;
    logic [31:0] model [int unsigned];

    always #2.5 clk = ~clk;

    pgwalk_top dut_i (.*);

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Memory model: random acks, reads from the sparse model, writes update it.
    always @(negedge clk) begin
        mem_ack <= 1'b0;
        if (rst_n && mem_valid && ($urandom % 3 != 0)) begin
            mem_ack <= 1'b1;
            if (mem_we) begin
                model[mem_addr] = mem_wdata;
                nwrites++;
            end else begin
                mem_rdata <= model.exists(mem_addr) ? model[mem_addr] : 32'h0;
                nreads++;
            end
        end
    end

    function automatic int l1s(); return int'(cfg_ptsize[4:0]); endfunction
    function automatic int l2s(); return int'(cfg_ptsize[20:16]); endfunction

    // Create table entries lazily along the walk path of va.
    task automatic prepare(input logic [31:0] va);
        logic [31:0] a1, a2, idx2;
        a1 = cfg_ptbase + ((va & 32'h7fffffff) >> l1s()) * 4;
        if (!model.exists(a1))
            model[a1] = ($urandom % 8 == 0) ? ($urandom & 32'hffff_fffe)
                      : (32'h0040_0000 + (((va & 32'h7fffffff) >> l1s()) & 32'hff) * 32'h10000
                         + ($urandom % 16) * 4) | 32'h1 | ($urandom & 32'h2);
        if (model[a1][0]) begin
            idx2 = ((va & 32'h7fffffff) >> l2s()) & ((32'h1 << (l1s() - l2s())) - 1);
            a2 = (model[a1] & ~32'h3) + idx2 * 4;
            if (!model.exists(a2))
                model[a2] = ($urandom % 8 == 0) ? ($urandom & 32'hffff_fffe)
                          : (($urandom & 32'h7fff_fffc) | 32'h1 | ($urandom & 32'h2));
        end
    endtask

    // Expected response computed from the requirements and the model.
    task automatic expect_walk(input logic [31:0] va, input bit wr,
                               output bit f, output logic [31:0] pa,
                               output bit wb, output logic [31:0] la, output bit mem_used);
        logic [31:0] a1, p1, leaf, om;
        f = 0; wb = 0; la = 0; pa = va; mem_used = 0;
        if (cfg_sys_mode || !cfg_xlate_en) return;
        if (va[31]) begin f = 1; return; end
        mem_used = 1;
        a1 = cfg_ptbase + (va >> l1s()) * 4;
        p1 = model.exists(a1) ? model[a1] : 0;
        if (!p1[0]) begin f = 1; return; end
        la = (p1 & ~32'h3) + (((va >> l2s()) & ((32'h1 << (l1s() - l2s())) - 1)) * 4);
        leaf = model.exists(la) ? model[la] : 0;
        if (!leaf[0]) begin f = 1; return; end
        om = (32'h1 << l2s()) - 1;
        pa = (leaf & ~om) + (va & om);
        wb = wr && !leaf[1];
    endtask

    task automatic run_one(input logic [31:0] va, input bit wr, input bit sys, input bit xl);
        bit f, wb, mu;
        logic [31:0] pa, la, old_leaf, fva_before;
        int r0, w0, cyc;
        @(negedge clk);
        cfg_sys_mode = sys; cfg_xlate_en = xl;
        req_vaddr = va; req_write = wr;
        if (!sys && xl && !va[31]) prepare(va);
        expect_walk(va, wr, f, pa, wb, la, mu);
        old_leaf = (la != 0 && model.exists(la)) ? model[la] : 32'h0;
        fva_before = fault_vaddr;
        r0 = nreads; w0 = nwrites;
        chk(req_ready == 1'b1, "R8 ready when idle", {31'b0, req_ready}, 32'h1);
        req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        cyc = 0;
        while (!rsp_valid && cyc < 200) begin @(negedge clk); cyc++; end
        chk(rsp_valid == 1'b1, "R8 response arrives", {31'b0, rsp_valid}, 32'h1);
        chk(rsp_fault == f, f ? "R6 fault flag" : "R5 no fault", {31'b0, rsp_fault}, {31'b0, f});
        if (!f) chk(rsp_paddr == pa, mu ? "R5 physical address" : "R1 passthrough", rsp_paddr, pa);
        else    chk(fault_vaddr == va, "R6 fault address held", fault_vaddr, va);
        if (!f && !mu) chk(cyc == 0, "R1 next-cycle response", cyc, 0);
        if (!mu) chk(nreads == r0, va[31] && !sys && xl ? "R2 no memory read" : "R1 no memory read", nreads - r0, 0);
        chk(nwrites - w0 == (wb ? 1 : 0), "R7 writeback count", nwrites - w0, wb ? 1 : 0);
        if (!f && mu && wr)
            chk(model[la] == (old_leaf | 32'h2), "R7 dirty bit set", model[la], old_leaf | 32'h2);
        if (!f && mu && !wr)
            chk(model[la] == old_leaf, "R7 read leaves entry", model[la], old_leaf);
        if (!f) chk(fault_vaddr == fva_before, "R6 fault address kept", fault_vaddr, fva_before);
        @(negedge clk);
        chk(rsp_valid == 1'b0, "R8 single-cycle response", {31'b0, rsp_valid}, 32'h0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(req_ready == 1'b1 && rsp_valid == 1'b0 && mem_valid == 1'b0, "R8 reset state",
            {29'b0, req_ready, rsp_valid, mem_valid}, 32'h4);
        rst_n = 1'b1;

        // Directed: 1 KiB pages, 2 MiB regions; pointer not page aligned (R4).
        cfg_ptbase = 32'h0010_0000; cfg_ptsize = 32'h000a_0015;
        model[32'h0010_000C] = 32'h0030_0007;
        model[32'h0030_0124] = 32'h1234_5C01;
        run_one(32'h0061_2345, 1'b0, 1'b0, 1'b1);
        chk(rsp_paddr == 32'h1234_5F45, "R3 R4 R5 directed translation", rsp_paddr, 32'h1234_5F45);
        run_one(32'h0061_2345, 1'b1, 1'b0, 1'b1);   // R7 clean leaf write
        run_one(32'h0061_2345, 1'b1, 1'b0, 1'b1);   // R7 already dirty
        model[32'h0010_0010] = 32'h0050_0000;       // invalid L1 entry
        run_one(32'h0080_0004, 1'b0, 1'b0, 1'b1);   // R6
        model[32'h0010_0014] = 32'h0060_0001;
        model[32'h0060_0000] = 32'h7777_7000;       // invalid leaf
        run_one(32'h00A0_0010, 1'b1, 1'b0, 1'b1);   // R6
        run_one(32'h8000_1234, 1'b0, 1'b0, 1'b1);   // R2
        run_one(32'h8000_1234, 1'b1, 1'b1, 1'b1);   // R1 system mode
        run_one(32'hC123_4567, 1'b1, 1'b0, 1'b0);   // R1 translation off

        // Random phases with varying size configurations and table bases.
        for (int ph = 0; ph < 8; ph++) begin
            int p2, p1;
            p2 = 10 + int'($urandom % 4);
            p1 = p2 + 1 + int'($urandom % 6);
            cfg_ptsize = (32'(p2) << 16) | 32'(p1);
            cfg_ptbase = 32'h0010_0000 + ($urandom % 64) * 32'h400 + ($urandom % 8) * 4;
            for (int k = 0; k < 40; k++) begin
                logic [31:0] va;
                int sel;
                sel = int'($urandom % 20);
                va = ((($urandom % 12) << p1) | ($urandom & ((32'h1 << p1) - 1))) & 32'h7fff_ffff;
                if (sel == 0) va[31] = 1'b1;
                run_one(va, 1'($urandom % 2), sel == 1, sel != 2);
            end
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule